// File: doc/BRIEF.md
# Multi-point thermal threshold monitor

The block watches temperature codes from up to four sensing points. A single valid strobe presents all points together. On each strobe, every enabled point is compared against five programmable limits: cold, hot, low offset, high offset and a hot-to-normal return level. An event that keeps occurring for a programmable number of samples sets a sticky bit in a 32-bit status word. The status bits, masked by an enable word, are ORed into one interrupt line. Software clears status bits by writing ones to the clear path.

On the same strobe the enabled points are merged into one protection value. The merge policy is one of three: truncated average, maximum, or one selected point. A bus-timeout pulse from the measurement fabric sets its own status bit. Immediate-sense and filtered-sense bits report sample activity for each point. Higher codes mean hotter. All comparisons are unsigned.

Configuration writes use a word write port. The write addresses are: 0 cold limit, 1 hot limit, 2 hot-to-normal limit, 3 high-offset limit, 4 low-offset limit, 5 interrupt enable word, 6 protection control, 7 point enable mask (bit p enables point p), 8 occurrence count.

Top module: `thermal_mon`

## Requirements
- R1: After reset, status_o, irq_o and prot_o are all zero.
- R2: For points p = 0, 1 and 2, the status bits are at 5p + k. For k = 0, cold is set when code <= the cold limit. For k = 1, hot is set when code >= the hot limit. For k = 2, low offset is set when code <= the low-offset limit. For k = 3, high offset is set when code >= the high-offset limit. Point 3 only takes part in merging.
- R3: Hot-to-normal (bit 5p + 4) can only fire for a point whose hot event has been flagged. It fires when the code is below the hot-to-normal limit. Flagging it disarms the point until the next hot flag.
- R4: An event is flagged on the (N+1)-th consecutive qualifying sample of its point, where N is the occurrence count, so N = 0 flags on the first sample. A non-qualifying sample restarts the count. The count also restarts after each flag.
- R5: A pulse on bus_to_i sets status bit 15.
- R6: Each accepted sample of point p < 3 sets bit 16 + p. Every second accepted sample of that point sets bit 19 + p.
- R7: A point whose mask bit is clear raises no status bits and is left out of the merge.
- R8: Status bits are sticky and are cleared by clr_i with ones in clr_mask_i. If a bit is set and cleared in the same cycle, the set wins. Bits 31..22 stay zero.
- R9: irq_o is the OR of status_o ANDed with the enable word.
- R10: Protection control bits [17:16] select the policy. With policy 0, prot_o is the sum of the enabled codes divided by their count, truncated.
- R11: With policy 1, prot_o is the largest enabled code.
- R12: With policy 2, prot_o is the code of the point selected by control bits [1:0]. If that point is disabled, prot_o holds.
- R13: prot_o updates in the cycle after a strobe. It holds for policy 3, for an empty mask, and when no strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| meas_i | input | NUM_PTS*TEMP_W | Codes of all points, point p at [p*TEMP_W +: TEMP_W] |
| meas_vld_i | input | 1 | Sample strobe for all points |
| bus_to_i | input | 1 | Bus-timeout pulse |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration address |
| wr_data_i | input | 32 | Configuration data |
| clr_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 32 | Ones select status bits to clear |
| status_o | output | 32 | Sticky status word |
| irq_o | output | 1 | Interrupt |
| prot_o | output | TEMP_W | Merged protection value |

## Verification
A clear of a status bit can land in the same cycle as a new event that sets that bit. In the random sweep, clear strobes with random masks are issued together with strobes and timeout pulses. A directed step also clears bit 15 while a timeout pulse is present. The bench model gives the set priority over the clear. It judges every status word against that model one cycle after each step.

// File: rtl/thm_pkg.sv
package thm_pkg;
  typedef enum logic [1:0] {
    POL_AVG = 2'd0,
    POL_MAX = 2'd1,
    POL_SEL = 2'd2,
    POL_RSV = 2'd3
  } policy_e;

  localparam int STAT_W    = 32;
  localparam int EVT_W     = 5;
  localparam int IRQ_PTS   = 3;
  localparam int EV_COLD   = 0;
  localparam int EV_HOT    = 1;
  localparam int EV_LOW    = 2;
  localparam int EV_HIGH   = 3;
  localparam int EV_H2N    = 4;
  localparam int TO_BIT    = 15;
  localparam int IMM_BASE  = 16;
  localparam int FILT_BASE = 19;

  localparam int A_COLD = 0;
  localparam int A_HOT  = 1;
  localparam int A_H2N  = 2;
  localparam int A_HIGH = 3;
  localparam int A_LOW  = 4;
  localparam int A_IEN  = 5;
  localparam int A_CTRL = 6;
  localparam int A_MASK = 7;
  localparam int A_DET  = 8;
endpackage

// File: rtl/thm_regs.sv
module thm_regs import thm_pkg::*; #(
  parameter int NUM_PTS = 4,
  parameter int TEMP_W  = 12,
  parameter int DET_W   = 4,
  parameter int ADDR_W  = 4,
  localparam int SEL_W  = $clog2(NUM_PTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [STAT_W-1:0]   wr_data_i,
  output logic [TEMP_W-1:0]   cold_thr_o,
  output logic [TEMP_W-1:0]   hot_thr_o,
  output logic [TEMP_W-1:0]   h2n_thr_o,
  output logic [TEMP_W-1:0]   high_thr_o,
  output logic [TEMP_W-1:0]   low_thr_o,
  output logic [STAT_W-1:0]   irq_en_o,
  output policy_e             policy_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [NUM_PTS-1:0]  mask_o,
  output logic [DET_W-1:0]    det_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_thr_o <= '0;
      hot_thr_o  <= '0;
      h2n_thr_o  <= '0;
      high_thr_o <= '0;
      low_thr_o  <= '0;
      irq_en_o   <= '0;
      policy_o   <= POL_AVG;
      sel_o      <= '0;
      mask_o     <= '0;
      det_n_o    <= '0;
    end else if (wr_en_i) begin
      case (int'(wr_addr_i))
        A_COLD: cold_thr_o <= wr_data_i[TEMP_W-1:0];
        A_HOT:  hot_thr_o  <= wr_data_i[TEMP_W-1:0];
        A_H2N:  h2n_thr_o  <= wr_data_i[TEMP_W-1:0];
        A_HIGH: high_thr_o <= wr_data_i[TEMP_W-1:0];
        A_LOW:  low_thr_o  <= wr_data_i[TEMP_W-1:0];
        A_IEN:  irq_en_o   <= wr_data_i;
        A_CTRL: begin
          policy_o <= policy_e'(wr_data_i[17:16]);
          sel_o    <= wr_data_i[SEL_W-1:0];
        end
        A_MASK: mask_o  <= wr_data_i[NUM_PTS-1:0];
        A_DET:  det_n_o <= wr_data_i[DET_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thm_point.sv
module thm_point import thm_pkg::*; #(
  parameter int TEMP_W = 12,
  parameter int DET_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [TEMP_W-1:0] meas_i,
  input  logic [TEMP_W-1:0] cold_thr_i,
  input  logic [TEMP_W-1:0] hot_thr_i,
  input  logic [TEMP_W-1:0] h2n_thr_i,
  input  logic [TEMP_W-1:0] high_thr_i,
  input  logic [TEMP_W-1:0] low_thr_i,
  input  logic [DET_W-1:0]  det_n_i,
  output logic [EVT_W-1:0]  evt_o,
  output logic              imm_o,
  output logic              filt_o
);
  logic [EVT_W-1:0] cond;
  logic [DET_W-1:0] cnt_q [EVT_W];
  logic             hot_armed_q;
  logic             filt_ph_q;

  always_comb begin
    cond[EV_COLD] = meas_i <= cold_thr_i;
    cond[EV_HOT]  = meas_i >= hot_thr_i;
    cond[EV_LOW]  = meas_i <= low_thr_i;
    cond[EV_HIGH] = meas_i >= high_thr_i;
    cond[EV_H2N]  = hot_armed_q && (meas_i < h2n_thr_i);
  end

  for (genvar k = 0; k < EVT_W; k++) begin : g_evt
    assign evt_o[k] = sample_i && cond[k] && (cnt_q[k] == det_n_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cnt_q[k] <= '0;
      else if (sample_i) begin
        if (!cond[k] || evt_o[k])         cnt_q[k] <= '0;
        else                              cnt_q[k] <= cnt_q[k] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_armed_q <= 1'b0;
      filt_ph_q   <= 1'b0;
    end else if (sample_i) begin
      filt_ph_q <= ~filt_ph_q;
      if (evt_o[EV_HOT])      hot_armed_q <= 1'b1;
      else if (evt_o[EV_H2N]) hot_armed_q <= 1'b0;
    end
  end

  assign imm_o  = sample_i;
  assign filt_o = sample_i && filt_ph_q;
endmodule

// File: rtl/thm_merge.sv
module thm_merge import thm_pkg::*; #(
  parameter int NUM_PTS = 4,
  parameter int TEMP_W  = 12,
  localparam int SEL_W  = $clog2(NUM_PTS),
  localparam int SUM_W  = TEMP_W + $clog2(NUM_PTS) + 1,
  localparam int CNT_W  = $clog2(NUM_PTS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_i,
  input  logic [NUM_PTS*TEMP_W-1:0] meas_i,
  input  logic [NUM_PTS-1:0]        mask_i,
  input  policy_e                   policy_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [TEMP_W-1:0]         prot_o
);
  logic [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]  cnt;
  logic [TEMP_W-1:0] max_v;
  logic [TEMP_W-1:0] sel_v;
  logic [TEMP_W-1:0] nxt;
  logic              load;

  always_comb begin
    sum   = '0;
    cnt   = '0;
    max_v = '0;
    for (int p = 0; p < NUM_PTS; p++) begin
      if (mask_i[p]) begin
        sum = sum + SUM_W'(meas_i[p*TEMP_W +: TEMP_W]);
        cnt = cnt + 1'b1;
        if (meas_i[p*TEMP_W +: TEMP_W] > max_v) max_v = meas_i[p*TEMP_W +: TEMP_W];
      end
    end
    sel_v = meas_i[int'(sel_i)*TEMP_W +: TEMP_W];
  end

  always_comb begin
    nxt  = prot_o;
    load = 1'b0;
    if (upd_i && (cnt != '0)) begin
      unique case (policy_i)
        POL_AVG: begin nxt = TEMP_W'(sum / SUM_W'(cnt)); load = 1'b1; end
        POL_MAX: begin nxt = max_v; load = 1'b1; end
        POL_SEL: begin nxt = sel_v; load = mask_i[sel_i]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prot_o <= '0;
    else if (load) prot_o <= nxt;
  end
endmodule

// File: rtl/thermal_mon.sv
module thermal_mon import thm_pkg::*; #(
  parameter int NUM_PTS = 4,
  parameter int TEMP_W  = 12,
  parameter int DET_W   = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PTS*TEMP_W-1:0] meas_i,
  input  logic                      meas_vld_i,
  input  logic                      bus_to_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [31:0]               wr_data_i,
  input  logic                      clr_i,
  input  logic [31:0]               clr_mask_i,
  output logic [31:0]               status_o,
  output logic                      irq_o,
  output logic [TEMP_W-1:0]         prot_o
);
  localparam int SEL_W = $clog2(NUM_PTS);

  logic [TEMP_W-1:0]  cold_thr, hot_thr, h2n_thr, high_thr, low_thr;
  logic [STAT_W-1:0]  irq_en;
  policy_e            policy;
  logic [SEL_W-1:0]   sel;
  logic [NUM_PTS-1:0] mask;
  logic [DET_W-1:0]   det_n;

  logic [EVT_W-1:0]   evt  [IRQ_PTS];
  logic [IRQ_PTS-1:0] imm, filt;
  logic [STAT_W-1:0]  set_vec;

  thm_regs #(.NUM_PTS(NUM_PTS), .TEMP_W(TEMP_W), .DET_W(DET_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cold_thr_o(cold_thr), .hot_thr_o(hot_thr), .h2n_thr_o(h2n_thr),
    .high_thr_o(high_thr), .low_thr_o(low_thr), .irq_en_o(irq_en),
    .policy_o(policy), .sel_o(sel), .mask_o(mask), .det_n_o(det_n)
  );

  for (genvar p = 0; p < IRQ_PTS; p++) begin : g_pt
    thm_point #(.TEMP_W(TEMP_W), .DET_W(DET_W)) pt_i (
      .clk_i, .rst_ni,
      .sample_i(meas_vld_i && mask[p]),
      .meas_i(meas_i[p*TEMP_W +: TEMP_W]),
      .cold_thr_i(cold_thr), .hot_thr_i(hot_thr), .h2n_thr_i(h2n_thr),
      .high_thr_i(high_thr), .low_thr_i(low_thr), .det_n_i(det_n),
      .evt_o(evt[p]), .imm_o(imm[p]), .filt_o(filt[p])
    );
  end

  thm_merge #(.NUM_PTS(NUM_PTS), .TEMP_W(TEMP_W)) merge_i (
    .clk_i, .rst_ni, .upd_i(meas_vld_i), .meas_i, .mask_i(mask),
    .policy_i(policy), .sel_i(sel), .prot_o
  );

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < IRQ_PTS; p++) begin
      set_vec[EVT_W*p +: EVT_W] = evt[p];
      set_vec[IMM_BASE+p]       = imm[p];
      set_vec[FILT_BASE+p]      = filt[p];
    end
    set_vec[TO_BIT] = bus_to_i;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~(clr_i ? clr_mask_i : 32'h0)) | set_vec;
  end

  assign irq_o = |(status_o & irq_en);
endmodule

// File: rtl/thermal_mon_chk.sv
module thermal_mon_chk #(
  parameter int TEMP_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              meas_vld_i,
  input logic              bus_to_i,
  input logic              clr_i,
  input logic [31:0]       status_o,
  input logic              irq_o,
  input logic [TEMP_W-1:0] prot_o
);
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ((status_o & $past(status_o)) == $past(status_o))); // R8
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(meas_vld_i) && !$past(bus_to_i)) |-> ((status_o & ~$past(status_o)) == 32'h0)); // R6
  AST_TIMEOUT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_to_i) |-> status_o[15]); // R5
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 32'h0) |-> !irq_o); // R9
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31:22] == 10'h0); // R8
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(meas_vld_i) |-> $stable(prot_o)); // R13
endmodule

bind thermal_mon thermal_mon_chk #(.TEMP_W(TEMP_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .meas_vld_i(meas_vld_i), .bus_to_i(bus_to_i),
  .clr_i(clr_i), .status_o(status_o), .irq_o(irq_o), .prot_o(prot_o)
);

// File: tb/thermal_mon_tb_top.sv
module thermal_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int TW = 12;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           rst_n = 1'b0;
  logic [NP*TW-1:0] meas = '0;
  logic           vld = 1'b0, to = 1'b0, wr_en = 1'b0, clr = 1'b0;
  logic [3:0]     waddr = '0;
  logic [31:0]    wdata = '0, cmask = '0;
  logic [31:0]    status;
  logic           irq;
  logic [TW-1:0]  prot;

  thermal_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .meas_i(meas), .meas_vld_i(vld), .bus_to_i(to),
    .wr_en_i(wr_en), .wr_addr_i(waddr), .wr_data_i(wdata), .clr_i(clr),
    .clr_mask_i(cmask), .status_o(status), .irq_o(irq), .prot_o(prot)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int cthr, hthr, nthr, hithr, lothr, det, pol, sel;
  logic [31:0] ien = '0;
  logic [3:0]  msk = '0;
  int          mcnt [3][5];
  bit          mhot [3], mfph [3];
  logic [31:0] mstat = '0;
  logic [TW-1:0] mprot = '0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = 4'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step(logic [NP*TW-1:0] mv, bit v, bit t, bit c, logic [31:0] cm);
    logic [31:0] setv;
    int vals [NP];
    bit cond [5];
    int sum, cnt, mx;
    setv = '0;
    for (int p = 0; p < NP; p++) vals[p] = int'(mv[p*TW +: TW]);
    if (v) begin
      for (int p = 0; p < 3; p++) begin
        if (msk[p]) begin
          cond[0] = vals[p] <= cthr;
          cond[1] = vals[p] >= hthr;
          cond[2] = vals[p] <= lothr;
          cond[3] = vals[p] >= hithr;
          cond[4] = mhot[p] && (vals[p] < nthr);
          for (int k = 0; k < 5; k++) begin
            if (cond[k] && mcnt[p][k] == det) begin setv[5*p+k] = 1'b1; mcnt[p][k] = 0; end
            else if (cond[k]) mcnt[p][k]++;
            else mcnt[p][k] = 0;
          end
          if (setv[5*p+1]) mhot[p] = 1'b1;
          else if (setv[5*p+4]) mhot[p] = 1'b0;
          setv[16+p] = 1'b1;
          if (mfph[p]) setv[19+p] = 1'b1;
          mfph[p] = ~mfph[p];
        end
      end
      sum = 0; cnt = 0; mx = 0;
      for (int p = 0; p < NP; p++) if (msk[p]) begin
        sum += vals[p]; cnt++; if (vals[p] > mx) mx = vals[p];
      end
      if (cnt != 0) begin
        if (pol == 0) mprot = TW'(sum / cnt);
        else if (pol == 1) mprot = TW'(mx);
        else if (pol == 2 && msk[sel]) mprot = TW'(vals[sel]);
      end
    end
    if (t) setv[15] = 1'b1;
    @(negedge clk);
    meas = mv; vld = v; to = t; clr = c; cmask = cm;
    @(posedge clk); #1;
    vld = 1'b0; to = 1'b0; clr = 1'b0;
    mstat = (mstat & ~(c ? cm : 32'h0)) | setv;
    chk("R2 R3 R4 R5 R6 R7 R8 status", status, mstat);
    chk("R9 irq", 32'(irq), 32'(|(mstat & ien)));
    chk("R10 R11 R12 R13 prot", 32'(prot), 32'(mprot));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NP*TW-1:0] cur;
    for (int p = 0; p < 3; p++) begin
      mhot[p] = 1'b0; mfph[p] = 1'b0;
      for (int k = 0; k < 5; k++) mcnt[p][k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R1 reset prot", 32'(prot), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    cthr = 300; hthr = 3000; nthr = 2200; hithr = 2600; lothr = 800;
    wr(0, 32'(cthr)); wr(1, 32'(hthr)); wr(2, 32'(nthr));
    wr(3, 32'(hithr)); wr(4, 32'(lothr));
    cur = '0;
    for (int d = 0; d < 2; d++) begin
      det = d * 2;
      wr(8, 32'(det));
      for (int pl = 0; pl < 4; pl++) begin
        for (int m = 0; m < 16; m++) begin
          pol = pl; sel = m % 4; msk = 4'(m); ien = rnd();
          wr(7, 32'(m)); wr(6, (32'(pl) << 16) | 32'(sel)); wr(5, ien);
          for (int s = 0; s < 8; s++) begin
            logic [31:0] r;
            r = rnd();
            for (int p = 0; p < NP; p++)
              if (r[p]) cur[p*TW +: TW] = TW'(rnd() % 4096);
            step(cur, r[8] | r[9], r[10] & r[11] & r[12], r[13] & r[14], rnd());
          end
        end
      end
    end

    // set and clear of bit 15 in the same cycle
    step(cur, 1'b0, 1'b1, 1'b0, 32'h0);
    step(cur, 1'b0, 1'b1, 1'b1, 32'h0000_8000);
    chk("R8 set beats clear", 32'(status[15]), 32'h1);
    step(cur, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R8 w1c all", status, 32'h0);
    // empty mask: no status, prot holds
    msk = 4'h0; wr(7, 32'h0);
    step({12'd4000, 12'd4000, 12'd4000, 12'd4000}, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R7 masked points silent", status, 32'h0);
    chk("R13 empty mask hold", 32'(prot), 32'(mprot));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule